// File: doc/BRIEF.md
# Memory Operation Ordering Queue with Load Dependence Check

This block holds the loads and stores of an out-of-order core in program order, one entry each, from allocation until commit. Entries are handed out at a circular tail. An entry's effective address is written once it has been computed, and a store's write data is written once it is available. On every cycle the block picks at most one load that may go ahead. A load goes ahead either as a data-cache read request or, when an older store to the same address already holds its data, as a forwarded value taken from that store. Stores leave the queue only at commit, and only then do they write memory.

Two policies are selected by `spec_mode`. With it low, a load waits until every older store has a known address. With it high, a load goes ahead past older stores whose addresses are still unknown. When one of those stores later resolves to the load's address, the block sends a replay pulse for the load, which then runs again. A branch flush moves the tail back to a given entry and frees that entry and everything younger.

Top module: `lsq_unit`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_idx` is 0, and `ld_req_valid`, `fwd_valid`, `st_wr_valid` and `replay_mask` are all 0.
- R2: Allocation hands out consecutive entry numbers, modulo DEPTH, starting at `alloc_idx`. `full` is 1 when DEPTH entries are live. An allocation while full is ignored and leaves `alloc_idx` unchanged.
- R3: A load with a known address and no older store that blocks it sends a cache request (`ld_req_valid`, with its entry number and address) one cycle after the edge at which its address was written.
- R4: With `spec_mode` 0, a load is held while any older store has an unknown address. It goes ahead one cycle after the edge at which the last such address is written.
- R5: When older stores with known addresses match the load's address, the load takes the data of the youngest of them on `fwd_data`, with `fwd_valid` and its entry number, and sends no cache request.
- R6: When that youngest matching older store has no data yet, the load waits. It is forwarded one cycle after the edge at which the data is written.
- R7: With `spec_mode` 1, a load goes ahead even when older stores have unknown addresses.
- R8: When an older store's address is written and equals the address of a load that has already gone ahead (or is going ahead in that same cycle), and no store between them has a known matching address, `replay_mask` bit (load entry number) is 1 on the next output update. The load is marked as not done and is executed again under the normal rules.
- R9: `commit_valid` retires the oldest entry only when that entry is ready: a load that has gone ahead, or a store with both address and data. Otherwise it is ignored. A retired store appears on `st_wr_valid`/`st_wr_addr`/`st_wr_data` one cycle after the commit edge. No store write happens at any other time.
- R10: `flush_valid` sets the tail to `flush_idx` and frees that entry and all younger ones. A freed entry never goes ahead, and `alloc_idx` reads `flush_idx` after the flush.
- R11: At most one load goes ahead per cycle. Among eligible loads the oldest in program order goes first, including across the wrap of the entry numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_mode | input | 1 | 1: loads may pass unresolved older stores |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_is_store | input | 1 | 1: new entry is a store, 0: a load |
| alloc_idx | output | IW | Entry number the next allocation receives |
| full | output | 1 | All DEPTH entries are live |
| addr_valid | input | 1 | Write an effective address |
| addr_idx | input | IW | Entry receiving the address |
| addr_val | input | AW | Effective address |
| data_valid | input | 1 | Write store data |
| data_idx | input | IW | Store entry receiving data |
| data_val | input | DW | Store data |
| commit_valid | input | 1 | Retire the oldest entry if ready |
| flush_valid | input | 1 | Roll the tail back |
| flush_idx | input | IW | First entry freed by the flush |
| ld_req_valid | output | 1 | Cache read request from a load |
| ld_req_idx | output | IW | Entry of the requesting load |
| ld_req_addr | output | AW | Read address |
| fwd_valid | output | 1 | Load satisfied from an older store |
| fwd_idx | output | IW | Entry of the forwarded load |
| fwd_data | output | DW | Forwarded store data |
| replay_mask | output | DEPTH | One bit per load entry that must re-execute |
| st_wr_valid | output | 1 | Committed store writes memory |
| st_wr_addr | output | AW | Store address |
| st_wr_data | output | DW | Store data |

## Verification
Assertions watch every cycle for the following: at most one load goes ahead per cycle, the picker chooses only an eligible load, the live count never exceeds DEPTH, a full queue stays full under a refused allocation, a store write appears only after a commit request, and a replay appears only after an address write. The ordering outcomes need the bench's scenarios: a load held behind an unresolved older store, forwarding from the youngest of two matching stores, waiting for late store data, oldest-first choice across the index wrap, the replay after a speculative load, and entries freed by a flush. Those scenarios depend on the contents of several entries over many cycles, so only a reference model can show them.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [0:0] {
    KIND_LOAD  = 1'b0,
    KIND_STORE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/lsq_load_check.sv
// Per-entry dependence check: may this load go ahead, from which store, and
// does the store address resolving this cycle force it to replay.
module lsq_load_check #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int SELF  = 0
) (
  input  logic [IW-1:0]             head,
  input  logic [DEPTH-1:0]          vld,
  input  logic [DEPTH-1:0]          is_st,
  input  logic [DEPTH-1:0]          a_ok,
  input  logic [DEPTH-1:0]          d_ok,
  input  logic [DEPTH-1:0]          done,
  input  logic [DEPTH-1:0][AW-1:0]  addr,
  input  logic                      spec_mode,
  input  logic                      res_valid,
  input  logic [IW-1:0]             res_idx,
  input  logic [AW-1:0]             res_addr,
  input  logic                      issuing_now,
  output logic                      can_issue,
  output logic                      has_src,
  output logic [IW-1:0]             src_idx,
  output logic                      replay_hit
);
  localparam logic [IW-1:0] ME = IW'(SELF);

  logic [IW-1:0] my_age, res_age, age_j, src_age;
  logic          unknown, between, is_load, hit;

  always_comb begin
    my_age  = ME - head;
    res_age = res_idx - head;
    is_load = vld[SELF] && !is_st[SELF] && a_ok[SELF];
    unknown = 1'b0;
    between = 1'b0;
    has_src = 1'b0;
    src_idx = '0;
    src_age = '0;
    age_j   = '0;
    for (int j = 0; j < DEPTH; j++) begin
      age_j = IW'(j) - head;
      if (vld[j] && is_st[j] && (age_j < my_age)) begin
        if (!a_ok[j]) unknown = 1'b1;
        else if (addr[j] == addr[SELF]) begin
          if (!has_src || (age_j > src_age)) begin
            has_src = 1'b1;
            src_idx = IW'(j);
            src_age = age_j;
          end
          if (age_j > res_age) between = 1'b1;
        end
      end
    end
    can_issue = is_load && !done[SELF] && !(unknown && !spec_mode)
                && !(has_src && !d_ok[src_idx]);
    hit = res_valid && (res_age < my_age) && (res_addr == addr[SELF])
          && is_load && (done[SELF] || issuing_now);
    replay_hit = hit && !between;
  end
endmodule

// File: rtl/lsq_oldest_pick.sv
// Chooses the requesting entry closest to the head.
module lsq_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] req,
  output logic             sel_valid,
  output logic [IW-1:0]    sel_idx
);
  logic [IW-1:0] best_age, age_i;

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    best_age  = '0;
    age_i     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      age_i = IW'(i) - head;
      if (req[i] && (!sel_valid || (age_i < best_age))) begin
        sel_valid = 1'b1;
        sel_idx   = IW'(i);
        best_age  = age_i;
      end
    end
  end

  // R11
  always_comb begin
    if (sel_valid) begin
      pick_req_chk: assert (req[sel_idx]);
    end
  end
endmodule

// File: rtl/lsq_unit.sv
module lsq_unit
  import lsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spec_mode,
  input  logic             alloc_valid,
  input  logic             alloc_is_store,
  output logic [IW-1:0]    alloc_idx,
  output logic             full,
  input  logic             addr_valid,
  input  logic [IW-1:0]    addr_idx,
  input  logic [AW-1:0]    addr_val,
  input  logic             data_valid,
  input  logic [IW-1:0]    data_idx,
  input  logic [DW-1:0]    data_val,
  input  logic             commit_valid,
  input  logic             flush_valid,
  input  logic [IW-1:0]    flush_idx,
  output logic             ld_req_valid,
  output logic [IW-1:0]    ld_req_idx,
  output logic [AW-1:0]    ld_req_addr,
  output logic             fwd_valid,
  output logic [IW-1:0]    fwd_idx,
  output logic [DW-1:0]    fwd_data,
  output logic [DEPTH-1:0] replay_mask,
  output logic             st_wr_valid,
  output logic [AW-1:0]    st_wr_addr,
  output logic [DW-1:0]    st_wr_data
);
  // Entry state
  logic [DEPTH-1:0]          vld_q, st_q, aok_q, dok_q, done_q;
  logic [DEPTH-1:0][AW-1:0]  addr_q;
  logic [DEPTH-1:0][DW-1:0]  data_q;
  logic [IW-1:0]             head_q, tail_q;
  logic [CW-1:0]             count_q;

  // Check results
  logic [DEPTH-1:0]          can_issue, has_src, rp_hit, issuing_vec;
  logic [DEPTH-1:0][IW-1:0]  src_idx_arr;
  logic                      sel_valid, sel_go, res_valid, head_ready;
  logic                      commit_go, do_alloc;
  logic [IW-1:0]             sel_idx, flush_age;
  op_kind_e                  kind_in;

  assign kind_in    = op_kind_e'(alloc_is_store);
  assign full       = (count_q == CW'(DEPTH));
  assign alloc_idx  = tail_q;
  assign do_alloc   = alloc_valid && !full && !flush_valid;
  assign res_valid  = addr_valid && vld_q[addr_idx] && st_q[addr_idx] && !aok_q[addr_idx];
  assign head_ready = vld_q[head_q] && (st_q[head_q] ? (aok_q[head_q] && dok_q[head_q])
                                                      : done_q[head_q]);
  assign commit_go  = commit_valid && (count_q != '0) && head_ready;
  assign flush_age  = flush_idx - head_q;
  assign sel_go     = sel_valid && !rp_hit[sel_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    assign issuing_vec[g] = sel_valid && (sel_idx == IW'(g));
    lsq_load_check #(.DEPTH(DEPTH), .AW(AW), .IW(IW), .SELF(g)) u_chk (
      .head       (head_q),
      .vld        (vld_q),
      .is_st      (st_q),
      .a_ok       (aok_q),
      .d_ok       (dok_q),
      .done       (done_q),
      .addr       (addr_q),
      .spec_mode  (spec_mode),
      .res_valid  (res_valid),
      .res_idx    (addr_idx),
      .res_addr   (addr_val),
      .issuing_now(issuing_vec[g]),
      .can_issue  (can_issue[g]),
      .has_src    (has_src[g]),
      .src_idx    (src_idx_arr[g]),
      .replay_hit (rp_hit[g])
    );
  end

  lsq_oldest_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .head     (head_q),
    .req      (can_issue),
    .sel_valid(sel_valid),
    .sel_idx  (sel_idx)
  );

  // Payload arrays: written without reset
  always_ff @(posedge clk) begin
    if (addr_valid && vld_q[addr_idx]) addr_q[addr_idx] <= addr_val;
    if (data_valid && vld_q[data_idx]) data_q[data_idx] <= data_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q        <= '0;
      st_q         <= '0;
      aok_q        <= '0;
      dok_q        <= '0;
      done_q       <= '0;
      head_q       <= '0;
      tail_q       <= '0;
      count_q      <= '0;
      ld_req_valid <= 1'b0;
      ld_req_idx   <= '0;
      ld_req_addr  <= '0;
      fwd_valid    <= 1'b0;
      fwd_idx      <= '0;
      fwd_data     <= '0;
      replay_mask  <= '0;
      st_wr_valid  <= 1'b0;
      st_wr_addr   <= '0;
      st_wr_data   <= '0;
    end else begin
      ld_req_valid <= 1'b0;
      fwd_valid    <= 1'b0;
      st_wr_valid  <= 1'b0;
      replay_mask  <= rp_hit;

      if (do_alloc) begin
        vld_q[tail_q]  <= 1'b1;
        st_q[tail_q]   <= (kind_in == KIND_STORE);
        aok_q[tail_q]  <= 1'b0;
        dok_q[tail_q]  <= 1'b0;
        done_q[tail_q] <= 1'b0;
        tail_q         <= tail_q + 1'b1;
      end
      if (addr_valid && vld_q[addr_idx]) aok_q[addr_idx] <= 1'b1;
      if (data_valid && vld_q[data_idx]) dok_q[data_idx] <= 1'b1;

      for (int g = 0; g < DEPTH; g++) begin
        if (rp_hit[g]) done_q[g] <= 1'b0;
      end

      if (sel_go) begin
        done_q[sel_idx] <= 1'b1;
        if (has_src[sel_idx]) begin
          fwd_valid <= 1'b1;
          fwd_idx   <= sel_idx;
          fwd_data  <= data_q[src_idx_arr[sel_idx]];
        end else begin
          ld_req_valid <= 1'b1;
          ld_req_idx   <= sel_idx;
          ld_req_addr  <= addr_q[sel_idx];
        end
      end

      if (commit_go) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
        if (st_q[head_q]) begin
          st_wr_valid <= 1'b1;
          st_wr_addr  <= addr_q[head_q];
          st_wr_data  <= data_q[head_q];
        end
      end

      if (flush_valid) begin
        for (int g = 0; g < DEPTH; g++) begin
          if ((IW'(g) - head_q) >= flush_age) vld_q[g] <= 1'b0;
        end
        tail_q <= flush_idx;
      end

      count_q <= (flush_valid ? CW'(flush_age) : count_q + CW'(do_alloc)) - CW'(commit_go);
    end
  end

  // R11
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld_req_valid && fwd_valid));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && alloc_valid && !commit_valid && !flush_valid) |=> full);
  // R9
  st_commit_chk: assert property (@(posedge clk) disable iff (rst)
    st_wr_valid |-> $past(commit_valid));
  // R8
  replay_src_chk: assert property (@(posedge clk) disable iff (rst)
    (replay_mask != '0) |-> $past(addr_valid));
endmodule

// File: tb/sim_lsq_unit.sv
module sim_lsq_unit;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spec_mode = 1'b0;
  logic alloc_valid = 1'b0, alloc_is_store = 1'b0;
  logic [2:0] alloc_idx;
  logic full;
  logic addr_valid = 1'b0;
  logic [2:0] addr_idx = '0;
  logic [15:0] addr_val = '0;
  logic data_valid = 1'b0;
  logic [2:0] data_idx = '0;
  logic [15:0] data_val = '0;
  logic commit_valid = 1'b0, flush_valid = 1'b0;
  logic [2:0] flush_idx = '0;
  logic ld_req_valid, fwd_valid, st_wr_valid;
  logic [2:0] ld_req_idx, fwd_idx;
  logic [15:0] ld_req_addr, fwd_data, st_wr_addr, st_wr_data;
  logic [7:0] replay_mask;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lsq_unit u0 (.*);

  // ---------------- reference model ----------------
  typedef struct {int idx; bit st, aok, dok, done; int addr, data;} ent_t;
  ent_t q[$];
  int m_tail;
  bit e_ld, e_fw, e_sw;
  int e_ldi, e_lda, e_fwi, e_fwd, e_swa, e_swd;
  bit [7:0] e_rp;

  function automatic void scan(int p, output bit unk, output bit fnd, output int sp);
    unk = 0; fnd = 0; sp = -1;
    for (int s = 0; s < p; s++)
      if (q[s].st) begin
        if (!q[s].aok) unk = 1;
        else if (q[s].addr == q[p].addr) begin fnd = 1; sp = s; end
      end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_tail = 0;
      e_ld = 0; e_fw = 0; e_sw = 0; e_rp = 0;
    end else begin
      int sel, head_i, fpos, r;
      bit unk, fnd, can_al, ok_c;
      int sp;
      can_al = (q.size() < D);
      head_i = (q.size() > 0) ? q[0].idx : m_tail;
      ok_c = commit_valid && q.size() > 0 &&
             (q[0].st ? (q[0].aok && q[0].dok) : q[0].done);
      fpos = (int'(flush_idx) - head_i + D) % D;
      sel = -1;
      for (int p = 0; p < q.size(); p++)
        if (sel < 0 && !q[p].st && q[p].aok && !q[p].done) begin
          scan(p, unk, fnd, sp);
          if (!(unk && !spec_mode) && !(fnd && !q[sp].dok)) sel = p;
        end
      e_rp = 0;
      r = -1;
      if (addr_valid)
        for (int p = 0; p < q.size(); p++)
          if (q[p].idx == addr_idx && q[p].st && !q[p].aok) r = p;
      if (r >= 0)
        for (int p = r + 1; p < q.size(); p++)
          if (!q[p].st && q[p].aok && (q[p].done || p == sel) && q[p].addr == addr_val) begin
            bit blk;
            blk = 0;
            for (int s = r + 1; s < p; s++)
              if (q[s].st && q[s].aok && q[s].addr == addr_val) blk = 1;
            if (!blk) e_rp[q[p].idx] = 1;
          end
      e_ld = 0; e_fw = 0; e_sw = 0;
      if (sel >= 0 && !e_rp[q[sel].idx]) begin
        scan(sel, unk, fnd, sp);
        q[sel].done = 1;
        if (fnd) begin e_fw = 1; e_fwi = q[sel].idx; e_fwd = q[sp].data; end
        else begin e_ld = 1; e_ldi = q[sel].idx; e_lda = q[sel].addr; end
      end
      for (int p = 0; p < q.size(); p++) if (e_rp[q[p].idx]) q[p].done = 0;
      for (int p = 0; p < q.size(); p++) begin
        if (addr_valid && q[p].idx == addr_idx) begin q[p].addr = addr_val; q[p].aok = 1; end
        if (data_valid && q[p].idx == data_idx) begin q[p].data = data_val; q[p].dok = 1; end
      end
      if (ok_c) begin
        if (q[0].st) begin e_sw = 1; e_swa = q[0].addr; e_swd = q[0].data; end
        void'(q.pop_front());
      end
      if (flush_valid) begin
        while (q.size() > fpos) void'(q.pop_back());
        m_tail = flush_idx;
      end else if (alloc_valid && can_al) begin
        ent_t n;
        n.idx = m_tail; n.st = alloc_is_store; n.aok = 0; n.dok = 0; n.done = 0;
        n.addr = 0; n.data = 0;
        q.push_back(n);
        m_tail = (m_tail + 1) % D;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks += 5;
      if (ld_req_valid !== e_ld || (e_ld && (ld_req_idx !== 3'(e_ldi) || ld_req_addr !== 16'(e_lda)))) begin
        errors++;
        $display("FAIL R3 cache request: got v=%0b i=%0d a=%h exp v=%0b i=%0d a=%h",
                 ld_req_valid, ld_req_idx, ld_req_addr, e_ld, e_ldi, e_lda);
      end
      if (fwd_valid !== e_fw || (e_fw && (fwd_idx !== 3'(e_fwi) || fwd_data !== 16'(e_fwd)))) begin
        errors++;
        $display("FAIL R5 forward: got v=%0b i=%0d d=%h exp v=%0b i=%0d d=%h",
                 fwd_valid, fwd_idx, fwd_data, e_fw, e_fwi, e_fwd);
      end
      if (replay_mask !== e_rp) begin
        errors++;
        $display("FAIL R8 replay mask: got %b exp %b", replay_mask, e_rp);
      end
      if (st_wr_valid !== e_sw || (e_sw && (st_wr_addr !== 16'(e_swa) || st_wr_data !== 16'(e_swd)))) begin
        errors++;
        $display("FAIL R9 store write: got v=%0b a=%h d=%h exp v=%0b a=%h d=%h",
                 st_wr_valid, st_wr_addr, st_wr_data, e_sw, e_swa, e_swd);
      end
      if (full !== (q.size() == D) || alloc_idx !== 3'(m_tail)) begin
        errors++;
        $display("FAIL R2 occupancy: got full=%0b tail=%0d exp full=%0b tail=%0d",
                 full, alloc_idx, (q.size() == D), m_tail);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_alloc(bit st, output int idx);
    idx = alloc_idx; alloc_valid = 1; alloc_is_store = st; tick(); alloc_valid = 0;
  endtask

  task automatic wr_addr(int i, int a);
    addr_valid = 1; addr_idx = 3'(i); addr_val = 16'(a); tick(); addr_valid = 0;
  endtask

  task automatic wr_data(int i, int d);
    data_valid = 1; data_idx = 3'(i); data_val = 16'(d); tick(); data_valid = 0;
  endtask

  task automatic commit_n(int n);
    for (int k = 0; k < n; k++) begin commit_valid = 1; tick(); end
    commit_valid = 0;
  endtask

  task automatic flush_to(int i);
    flush_valid = 1; flush_idx = 3'(i); tick(); flush_valid = 0;
  endtask

  initial begin
    int l0, s1, l2, s3, s4, l5, s6, l7, l8, x, tmp;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk(full == 0 && alloc_idx == 0, "R1 empty after reset", alloc_idx, 0);
    chk(!ld_req_valid && !fwd_valid && !st_wr_valid && replay_mask == 0,
        "R1 idle outputs", {ld_req_valid, fwd_valid, st_wr_valid}, 0);

    // Conservative policy
    do_alloc(0, l0); do_alloc(1, s1); do_alloc(0, l2);
    chk(alloc_idx == 3 && l2 == 2, "R2 in-order allocation", alloc_idx, 3);
    wr_addr(l0, 'h10); tick();
    chk(ld_req_valid && ld_req_idx == 3'(l0) && ld_req_addr == 'h10, "R3 request one cycle after address", ld_req_idx, l0);
    wr_addr(l2, 'h20); tick(); tick();
    chk(!ld_req_valid, "R4 held behind unknown store", ld_req_valid, 0);
    wr_addr(s1, 'h30);
    chk(!ld_req_valid, "R4 held at resolution edge", ld_req_valid, 0);
    tick();
    chk(ld_req_valid && ld_req_idx == 3'(l2), "R4 released after store address", ld_req_idx, l2);
    commit_n(2);
    chk(!st_wr_valid, "R9 commit of store without data ignored", st_wr_valid, 0);
    wr_data(s1, 'h1234);
    commit_n(1);
    chk(st_wr_valid && st_wr_addr == 'h30 && st_wr_data == 'h1234, "R9 store writes at commit", st_wr_data, 'h1234);
    commit_n(1);

    // Forwarding
    do_alloc(1, s3); do_alloc(1, s4); do_alloc(0, l5);
    wr_addr(s3, 'h40); wr_data(s3, 'haaaa); wr_addr(s4, 'h40); wr_addr(l5, 'h40); tick();
    chk(!fwd_valid && !ld_req_valid, "R6 wait for youngest store data", fwd_valid, 0);
    wr_data(s4, 'hbbbb); tick();
    chk(fwd_valid && fwd_idx == 3'(l5) && fwd_data == 'hbbbb, "R5 forward from youngest match", fwd_data, 'hbbbb);
    chk(!ld_req_valid, "R5 no cache request on forward", ld_req_valid, 0);
    commit_n(3);

    // Oldest first across wrap
    do_alloc(1, s6); do_alloc(0, l7); do_alloc(0, l8);
    wr_addr(l8, 'h50); wr_addr(l7, 'h60); wr_addr(s6, 'h70); tick();
    chk(ld_req_valid && ld_req_idx == 3'(l7), "R11 oldest load first", ld_req_idx, l7);
    tick();
    chk(ld_req_valid && ld_req_idx == 3'(l8), "R11 younger load next", ld_req_idx, l8);
    wr_data(s6, 1);
    commit_n(3);

    // Full and flush
    tmp = alloc_idx;
    for (int k = 0; k < D; k++) do_alloc(0, x);
    chk(full == 1, "R2 full after DEPTH allocations", full, 1);
    do_alloc(0, x);
    chk(full == 1 && alloc_idx == 3'(tmp), "R2 allocation while full ignored", alloc_idx, tmp);
    flush_to((tmp + 2) % D);
    chk(!full && alloc_idx == 3'((tmp + 2) % D), "R10 tail moved back", alloc_idx, (tmp + 2) % D);
    do_alloc(0, x);
    wr_addr((tmp + 3) % D, 'h99); tick(); tick();
    chk(!ld_req_valid, "R10 freed entry never goes ahead", ld_req_valid, 0);
    flush_to(tmp);
    chk(alloc_idx == 3'(tmp) && !full, "R10 flush empties queue", alloc_idx, tmp);

    // Speculative policy
    spec_mode = 1;
    do_alloc(1, s1); do_alloc(0, l2); do_alloc(0, x);
    wr_addr(l2, 'h80); tick();
    chk(ld_req_valid && ld_req_idx == 3'(l2), "R7 load passes unknown store", ld_req_idx, l2);
    wr_addr(x, 'h90); tick();
    chk(ld_req_valid && ld_req_idx == 3'(x), "R7 second load passes", ld_req_idx, x);
    wr_addr(s1, 'h80);
    chk(replay_mask == 8'(1 << l2), "R8 replay of matching load only", replay_mask, 1 << l2);
    tick();
    chk(!fwd_valid && !ld_req_valid, "R8 replayed load waits for data", fwd_valid, 0);
    wr_data(s1, 'h5555); tick();
    chk(fwd_valid && fwd_idx == 3'(l2) && fwd_data == 'h5555, "R8 re-execution forwards", fwd_data, 'h5555);
    commit_n(3);
    spec_mode = 0;
    tick(); tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule